// File: doc/BRIEF.md
# Interrupt Request Front End with Reset-Time Mode Capture

This block sits between the six interrupt request pins of a processor and its core. After reset it turns the active-low pin levels into active-high request bits for the core. Each line takes one of two paths, chosen by a parameter mask. A synchronizing line passes through two flip-flops, so an asynchronous source may drive it safely. A direct line passes through a single register and reaches the core one cycle earlier. A direct line must therefore be driven by logic that is already synchronous to the core clock.

While reset is held, a contiguous group of the same pins serves as mode configuration inputs instead. One of these bits selects endianness, and the others are reserved options. The block captures the pin levels present in the final clock cycle of reset. It holds that value until the next reset, so the pins are free to carry interrupts once reset ends.

Reset is synchronous and active low. The configuration register loads at every clock edge where reset is sampled low, so it ends up holding the pin levels from the last reset cycle.

Top module: `irqfe_top`

## Requirements
- R1: `irq_req_o[i]` is high when pin `irq_pin_n[i]` is low (active) and low when the pin is high, after the lane's latency; there are 6 lines by default.
- R2: On a synchronizing lane, a pin level sampled at clock edge k appears on the output just after edge k+1 (two register stages). By default lanes 0 to 3 synchronize.
- R3: On a direct lane, a pin level sampled at clock edge k appears on the output just after edge k (one register stage). By default lanes 4 and 5 are direct (mask 6'b110000).
- R4: While `rst_n` is low, every `irq_req_o` bit is 0, whatever the pin levels. The first output after reset release reflects only pin levels sampled at edges where `rst_n` was high.
- R5: `mode_cfg_o[j]` equals the raw level of pin `irq_pin_n[2+j]`, for j = 0..3, at the last clock edge where `rst_n` was sampled low. Bit 0 is the endianness option and bits 1 to 3 are reserved options.
- R6: While `rst_n` stays high, `mode_cfg_o` does not change, whatever the pins do.
- R7: After reset, the configuration pins (lanes 2 to 5) act only as interrupt lines, with the latency of their lane kind.
- R8: A pin asserted for exactly one cycle gives exactly one cycle of output request, on both lane kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low; also the mode capture window |
| irq_pin_n | input | N_LINES | Interrupt pins, active low; configuration inputs during reset |
| irq_req_o | output | N_LINES | Interrupt requests to the core, active high |
| mode_cfg_o | output | CFG_W | Mode bits latched in the last reset cycle |

## Verification
The bench drives a single-cycle pulse on each lane in turn. The time at which each pulse shows up separates direct lanes from synchronizing lanes and shows whether a lane has one stage too many or too few. Dense patterns change every pin on every cycle, which exposes any cross-lane mixing or inversion error. Two reset windows change the pins on every reset cycle, so only a capture taken in the last cycle matches the expected mode bits. Pin activity after reset then shows that the mode bits stay fixed while the same pins keep producing requests.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
   typedef enum logic {
      LANE_SYNC   = 1'b0,
      LANE_DIRECT = 1'b1
   } lane_kind_e;

   localparam int unsigned SYNC_STAGES   = 2;
   localparam int unsigned DIRECT_STAGES = 1;
endpackage

// File: rtl/irqfe_lane.sv
module irqfe_lane
   import irqfe_pkg::*;
#(
   parameter lane_kind_e KIND = LANE_SYNC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic req_o
);
   logic act;
   logic req_raw;

   assign act = ~pin_n;

   generate
      if (KIND == LANE_DIRECT) begin : g_direct
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= act;
         end
         assign req_raw = q;

         // R3: one register stage between pin and core
         p_direct_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (req_o == $past(act)));
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stg;
         always_ff @(posedge clk) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[SYNC_STAGES-2:0], act};
         end
         assign req_raw = stg[SYNC_STAGES-1];

         // R2: two register stages between pin and core
         p_sync_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)) |-> (req_o == $past(act, 2)));
      end
   endgenerate

   assign req_o = req_raw & rst_n;
endmodule

// File: rtl/irqfe_cfg_latch.sv
module irqfe_cfg_latch #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_lvl,
   output logic [W-1:0] cfg_o
);
   logic primed;

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_o <= pin_lvl;
   end

   always_ff @(posedge clk) primed <= 1'b1;

   // R5: an edge with reset low loads the pin levels seen at that edge
   p_cfg_capture_r5: assert property (@(posedge clk)
      (primed && $past(primed) && !$past(rst_n)) |-> (cfg_o == $past(pin_lvl)));

   // R6: mode bits are frozen while reset stays released
   p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(rst_n)) |-> $stable(cfg_o));
endmodule

// File: rtl/irqfe_top.sv
module irqfe_top
   import irqfe_pkg::*;
#(
   parameter int unsigned         N_LINES     = 6,
   parameter logic [N_LINES-1:0]  DIRECT_MASK = 6'b110000,
   parameter int unsigned         CFG_LSB     = 2,
   parameter int unsigned         CFG_W       = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_pin_n,
   output logic [N_LINES-1:0] irq_req_o,
   output logic [CFG_W-1:0]   mode_cfg_o
);
   localparam int unsigned CFG_MSB = CFG_LSB + CFG_W - 1;

   generate
      if (N_LINES < 1) begin : g_bad_lines
         $error("irqfe_top: N_LINES must be at least 1");
      end
      if (CFG_W < 1) begin : g_bad_cfgw
         $error("irqfe_top: CFG_W must be at least 1");
      end
      if (CFG_MSB >= N_LINES) begin : g_bad_cfgrange
         $error("irqfe_top: configuration field exceeds the pin count");
      end
   endgenerate

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_lane
         localparam lane_kind_e K = DIRECT_MASK[i] ? LANE_DIRECT : LANE_SYNC;
         irqfe_lane #(.KIND(K)) i_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (irq_pin_n[i]),
            .req_o (irq_req_o[i])
         );
      end
   endgenerate

   irqfe_cfg_latch #(.W(CFG_W)) i_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_lvl (irq_pin_n[CFG_MSB:CFG_LSB]),
      .cfg_o   (mode_cfg_o)
   );

   // R4: no request reaches the core while reset is held
   p_quiet_in_reset_r4: assert property (@(posedge clk)
      !rst_n |=> (!rst_n |-> (irq_req_o == '0)));
endmodule

// File: tb/test_irqfe_top.sv
module test_irqfe_top;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 6;
   localparam logic [N-1:0] DIR = 6'b110000;
   localparam int WATCHDOG   = 5000;

   typedef struct {
      logic [N-1:0] exp;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_pin_n = '1;
   logic [N-1:0] irq_req_o;
   logic [3:0]   mode_cfg_o;

   item_t        sb[$];
   logic [N-1:0] prev_act = '0;
   logic [3:0]   cfg_exp = '0;
   int           total = 0;
   int           bad = 0;
   bit           done = 0;

   irqfe_top i_irqfe_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_pin_n  (irq_pin_n),
      .irq_req_o  (irq_req_o),
      .mode_cfg_o (mode_cfg_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // driver: one cycle of stimulus, expected output pushed to the scoreboard
   task automatic drive(input logic r, input logic [N-1:0] pins, input string tag);
      item_t it;
      @(negedge clk);
      rst_n     = r;
      irq_pin_n = pins;
      if (!r) begin
         it.exp   = '0;
         prev_act = '0;
         cfg_exp  = pins[5:2];
      end else begin
         it.exp   = (DIR & ~pins) | (~DIR & prev_act);
         prev_act = ~pins;
      end
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic check_cfg(input logic [3:0] exp, input string tag);
      @(negedge clk);
      total++;
      if (mode_cfg_o !== exp) begin
         bad++;
         $display("FAIL %s mode_cfg act=%b exp=%b", tag, mode_cfg_o, exp);
      end
   endtask

   // monitor: compares each produced output with the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (irq_req_o !== it.exp) begin
               bad++;
               $display("FAIL %s irq_req act=%b exp=%b", it.tag, irq_req_o, it.exp);
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R4: all pins active during reset, outputs must stay quiet
      drive(1'b0, 6'b000000, "R4");
      drive(1'b0, 6'b000000, "R4");
      drive(1'b0, 6'b010010, "R4");
      drive(1'b0, 6'b101101, "R4 R5");
      // first released cycle: only the direct lanes may respond
      drive(1'b1, 6'b000000, "R4 R3");
      check_cfg(4'b1011, "R5");
      drive(1'b1, 6'b111111, "R2 R3");
      drive(1'b1, 6'b111111, "R1");
      // R8: single-cycle pulses on every lane in turn
      for (int i = 0; i < N; i++) begin
         drive(1'b1, ~(6'b1 << i), "R8 R2 R3");
         drive(1'b1, 6'b111111, "R8");
         drive(1'b1, 6'b111111, "R8");
      end
      // dense patterns, every pin changing
      drive(1'b1, 6'b010101, "R1");
      drive(1'b1, 6'b101010, "R1");
      drive(1'b1, 6'b001100, "R1");
      drive(1'b1, 6'b110011, "R1");
      drive(1'b1, 6'b000000, "R1");
      drive(1'b1, 6'b111000, "R1");
      // R7: config pins toggled after reset act as interrupts only
      drive(1'b1, 6'b000011, "R7");
      drive(1'b1, 6'b111111, "R7");
      drive(1'b1, 6'b010111, "R7");
      drive(1'b1, 6'b111111, "R7");
      drive(1'b1, 6'b111111, "R7");
      check_cfg(4'b1011, "R6");
      // second reset, pins move every cycle; only the final level counts
      drive(1'b0, 6'b111111, "R4");
      drive(1'b0, 6'b000000, "R4");
      drive(1'b0, 6'b101110, "R4");
      drive(1'b0, 6'b010011, "R4 R5");
      drive(1'b1, 6'b111111, "R4");
      check_cfg(4'b0100, "R5");
      drive(1'b1, 6'b000000, "R1 R7");
      drive(1'b1, 6'b111111, "R1 R7");
      drive(1'b1, 6'b100001, "R1");
      drive(1'b1, 6'b111111, "R1");
      drive(1'b1, 6'b111111, "R1");
      check_cfg(4'b0100, "R6");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule